// File: doc/BRIEF.md
# DMA Block-End Controller with Pointer Swap Protection

This block serves one DMA channel of a timer peripheral. It holds two pointer pairs, called even and odd, and each pair has an address and a transfer count. The pairs work in ping-pong fashion. Each acknowledged request gives out the current address, then advances that address and decrements the count. When the count runs out, the block flags end-of-block (EOB). If swap mode is on, it then flips a toggle bit so that later transfers use the other pair, while software reloads the pair that has just finished.

Software must clear EOB only after it has reloaded the finished pair. If a second block ends while EOB is still set, the block does not swap. It clears the channel's DMA mask, which stops all further transfers until software steps in. A request that arrives while the mask is off is not acknowledged; it sets a pending bit and an overrun bit instead. The mask can be set again only after pending has been cleared. The interrupt output is the OR of EOB and overrun, each gated by its own enable bit.

Top module: `dma_blockend_ctrl`

## Requirements
- R1: After synchronous reset, the following are all zero: every pointer, the control register, EOB, toggle, mask, pending and overrun. `dma_ack` and `irq` are also low.
- R2: A request with the channel enabled (control register at address 4, bit 0) and the mask at 1 is acknowledged on the next clock. `dma_addr` then carries the address of the active pair. That pair's address goes up by one and its count goes down by one. The even pair is at addresses 0 (address) and 1 (count), the odd pair at 2 and 3, and pair 0 (even) is active while toggle is 0.
- R3: An acknowledged transfer that takes the count from 1 to 0 is a block end, and it sets EOB. EOB reads at address 5, bit 0. A stored count of 0 gives a block of 65536 transfers.
- R4: When swap mode is on (address 4, bit 1) and EOB was clear, a block end inverts toggle (address 5, bit 1). The next transfers use the other pair.
- R5: A block end while EOB is already set clears the mask (address 7, bit 0), keeps EOB at 1 and leaves toggle unchanged.
- R6: When swap mode is off, a block end sets EOB and clears the mask, and toggle stays as it was.
- R7: A request with the channel enabled and the mask at 0 gets no acknowledge. It sets pending (address 6, bit 0) and overrun (address 6, bit 1). Writing 1 to either bit at address 6 clears that bit.
- R8: Writing 0 to address 5, bit 0 clears EOB. Writing 1 sets EOB only when test enable (address 4, bit 2) is 1; otherwise the write has no effect.
- R9: Writing 1 to address 7 sets the mask only while pending is 0. Writing 0 clears the mask.
- R10: `irq` equals (EOB and address 4 bit 3) OR (overrun and address 4 bit 4). It stays high until software clears the source bit or its enable bit.
- R11: While the channel is disabled, requests are ignored: there is no acknowledge, and pointers, pending and overrun keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write address |
| reg_wdata | input | PW | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | PW | Read data for `reg_raddr`, combinational |
| dma_req | input | 1 | Transfer request, one per cycle high |
| dma_ack | output | 1 | Request served, one cycle after the request |
| dma_addr | output | PW | Address of the served transfer, valid with `dma_ack` |
| irq | output | 1 | Level interrupt request |

## Verification
A write or a request presented in cycle N takes effect at the rising edge that ends cycle N. From then on `dma_ack`, `dma_addr`, every flag and `irq` show the result. Read data follows `reg_raddr` in the same cycle, with no register in the path. The bench drives inputs on the falling edge and checks the directed results just after the following falling edge, which is one full edge after the stimulus. On every cycle, one nanosecond before the rising edge, it also compares the outputs with a behavioural model that has advanced by the same number of edges.

// File: rtl/dbe_pkg.sv
package dbe_pkg;

    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        RA_EVEN_ADDR = 3'd0,
        RA_EVEN_CNT  = 3'd1,
        RA_ODD_ADDR  = 3'd2,
        RA_ODD_CNT   = 3'd3,
        RA_CTRL      = 3'd4,
        RA_EOB       = 3'd5,
        RA_PEND      = 3'd6,
        RA_MASK      = 3'd7
    } reg_sel_e;

    // Control word; packed so that chan_en sits at bit 0
    typedef struct packed {
        logic ovr_ie;
        logic eob_ie;
        logic test_en;
        logic swap_en;
        logic chan_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic eob;
        logic toggle;
        logic mask;
        logic pend;
        logic ovr;
    } flags_t;

    typedef struct packed {
        logic serve;
        logic reject;
        logic blk_end;
    } dma_evt_t;

    typedef struct packed {
        logic eob_clr;
        logic eob_set;
        logic pend_clr;
        logic ovr_clr;
        logic mask_set;
        logic mask_clr;
    } sw_cmd_t;

    // Hardware block end closes the channel if EOB is still up or swapping is off
    function automatic logic end_closes_mask(input logic eob_now, input logic swap_on);
        return eob_now || !swap_on;
    endfunction

    function automatic logic end_swaps(input logic eob_now, input logic swap_on);
        return !eob_now && swap_on;
    endfunction

endpackage

// File: rtl/dbe_ptr_bank.sv
module dbe_ptr_bank
    import dbe_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sel,
    input  logic               step,
    input  logic               wr_en,
    input  logic [1:0]         wr_idx,
    input  logic [PW-1:0]      wr_data,
    output logic [PW-1:0]      cur_addr,
    output logic               cur_last,
    output logic [1:0][PW-1:0] pair_addr,
    output logic [1:0][PW-1:0] pair_cnt
);

    localparam int NPAIR = 2;
    localparam logic [PW-1:0] ONE = PW'(1);

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        logic [PW-1:0] addr_q;
        logic [PW-1:0] cnt_q;
        logic          hw_step;

        assign hw_step = step && (sel == 1'(p));

        always_ff @(posedge clk) begin
            if (rst) begin
                addr_q <= '0;
                cnt_q  <= '0;
            end else begin
                if (wr_en && wr_idx == {1'(p), 1'b0}) addr_q <= wr_data;
                if (wr_en && wr_idx == {1'(p), 1'b1}) cnt_q  <= wr_data;
                // a transfer on this pair overrides a same-cycle software write
                if (hw_step) begin
                    addr_q <= addr_q + ONE;
                    cnt_q  <= cnt_q - ONE;
                end
            end
        end

        assign pair_addr[p] = addr_q;
        assign pair_cnt[p]  = cnt_q;
    end

    assign cur_addr = pair_addr[sel];
    assign cur_last = (pair_cnt[sel] == ONE);

endmodule

// File: rtl/dbe_flags.sv
module dbe_flags
    import dbe_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  dma_evt_t evt,
    input  ctrl_t    ctrl,
    input  sw_cmd_t  cmd,
    output flags_t   flags
);

    flags_t f_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q <= '0;
        end else begin
            // EOB: hardware end and test-mode set win over a clear
            if (evt.blk_end || cmd.eob_set) f_q.eob <= 1'b1;
            else if (cmd.eob_clr)           f_q.eob <= 1'b0;

            if (evt.blk_end && end_swaps(f_q.eob, ctrl.swap_en))
                f_q.toggle <= !f_q.toggle;

            // mask: protection clear beats any software set
            if (evt.blk_end && end_closes_mask(f_q.eob, ctrl.swap_en)) f_q.mask <= 1'b0;
            else if (cmd.mask_clr)                                     f_q.mask <= 1'b0;
            else if (cmd.mask_set && !f_q.pend)                        f_q.mask <= 1'b1;

            if (evt.reject)        f_q.pend <= 1'b1;
            else if (cmd.pend_clr) f_q.pend <= 1'b0;

            if (evt.reject)        f_q.ovr <= 1'b1;
            else if (cmd.ovr_clr)  f_q.ovr <= 1'b0;
        end
    end

    assign flags = f_q;

endmodule

// File: rtl/dbe_regif.sv
module dbe_regif
    import dbe_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [REG_AW-1:0]  waddr,
    input  logic [PW-1:0]      wdata,
    input  logic [REG_AW-1:0]  raddr,
    input  flags_t             flags,
    input  logic [1:0][PW-1:0] pair_addr,
    input  logic [1:0][PW-1:0] pair_cnt,
    output ctrl_t              ctrl,
    output sw_cmd_t            cmd,
    output logic               ptr_we,
    output logic [1:0]         ptr_idx,
    output logic [PW-1:0]      rdata
);

    ctrl_t    ctrl_q;
    reg_sel_e wsel;
    reg_sel_e rsel;

    assign wsel = reg_sel_e'(waddr);
    assign rsel = reg_sel_e'(raddr);

    always_ff @(posedge clk) begin
        if (rst)                         ctrl_q <= '0;
        else if (we && wsel == RA_CTRL)  ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
    end

    assign ctrl    = ctrl_q;
    assign ptr_idx = waddr[1:0];

    always_comb begin
        cmd    = '0;
        ptr_we = 1'b0;
        if (we) begin
            unique case (wsel)
                RA_EVEN_ADDR, RA_EVEN_CNT,
                RA_ODD_ADDR, RA_ODD_CNT: ptr_we = 1'b1;
                RA_EOB: begin
                    cmd.eob_clr = !wdata[0];
                    cmd.eob_set = wdata[0] && ctrl_q.test_en;
                end
                RA_PEND: begin
                    cmd.pend_clr = wdata[0];
                    cmd.ovr_clr  = wdata[1];
                end
                RA_MASK: begin
                    cmd.mask_set = wdata[0];
                    cmd.mask_clr = !wdata[0];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (rsel)
            RA_EVEN_ADDR: rdata = pair_addr[0];
            RA_EVEN_CNT:  rdata = pair_cnt[0];
            RA_ODD_ADDR:  rdata = pair_addr[1];
            RA_ODD_CNT:   rdata = pair_cnt[1];
            RA_CTRL:      rdata[CTRL_W-1:0] = ctrl_q;
            RA_EOB:       rdata[1:0] = {flags.toggle, flags.eob};
            RA_PEND:      rdata[1:0] = {flags.ovr, flags.pend};
            RA_MASK:      rdata[0]   = flags.mask;
            default:      rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_blockend_ctrl.sv
module dma_blockend_ctrl
    import dbe_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_waddr,
    input  logic [PW-1:0]     reg_wdata,
    input  logic [REG_AW-1:0] reg_raddr,
    output logic [PW-1:0]     reg_rdata,
    input  logic              dma_req,
    output logic              dma_ack,
    output logic [PW-1:0]     dma_addr
    ,output logic             irq
);

    ctrl_t              ctrl_q;
    flags_t             flags_q;
    sw_cmd_t            cmd;
    dma_evt_t           evt;
    logic               ptr_we;
    logic [1:0]         ptr_idx;
    logic [PW-1:0]      cur_addr;
    logic               cur_last;
    logic [1:0][PW-1:0] pair_addr;
    logic [1:0][PW-1:0] pair_cnt;
    logic               ack_q;
    logic [PW-1:0]      addr_q;

    assign evt.serve   = dma_req && ctrl_q.chan_en && flags_q.mask;
    assign evt.reject  = dma_req && ctrl_q.chan_en && !flags_q.mask;
    assign evt.blk_end = evt.serve && cur_last;

    dbe_regif #(.PW(PW)) u_regif (
        .clk       (clk),
        .rst       (rst),
        .we        (reg_we),
        .waddr     (reg_waddr),
        .wdata     (reg_wdata),
        .raddr     (reg_raddr),
        .flags     (flags_q),
        .pair_addr (pair_addr),
        .pair_cnt  (pair_cnt),
        .ctrl      (ctrl_q),
        .cmd       (cmd),
        .ptr_we    (ptr_we),
        .ptr_idx   (ptr_idx),
        .rdata     (reg_rdata)
    );

    dbe_ptr_bank #(.PW(PW)) u_ptrs (
        .clk       (clk),
        .rst       (rst),
        .sel       (flags_q.toggle),
        .step      (evt.serve),
        .wr_en     (ptr_we),
        .wr_idx    (ptr_idx),
        .wr_data   (reg_wdata),
        .cur_addr  (cur_addr),
        .cur_last  (cur_last),
        .pair_addr (pair_addr),
        .pair_cnt  (pair_cnt)
    );

    dbe_flags u_flags (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .ctrl  (ctrl_q),
        .cmd   (cmd),
        .flags (flags_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            ack_q <= evt.serve;
            if (evt.serve) addr_q <= cur_addr;
        end
    end

    assign dma_ack  = ack_q;
    assign dma_addr = addr_q;
    assign irq      = (flags_q.eob && ctrl_q.eob_ie) || (flags_q.ovr && ctrl_q.ovr_ie);

endmodule

// File: rtl/dbe_ctrl_chk.sv
module dbe_ctrl_chk
    import dbe_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   dma_req,
    input logic   dma_ack,
    input logic   irq,
    input logic   blk_end,
    input ctrl_t  ctrl,
    input flags_t flags
);

    AST_ACK_NEEDS_OPEN: assert property (@(posedge clk) disable iff (rst)
        dma_ack |-> $past(dma_req && ctrl.chan_en && flags.mask)); // R2

    AST_END_SETS_EOB: assert property (@(posedge clk) disable iff (rst)
        blk_end |=> flags.eob); // R3

    AST_GUARD_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (blk_end && flags.eob) |=> (!flags.mask && flags.eob)); // R5

    AST_GUARD_NO_SWAP: assert property (@(posedge clk) disable iff (rst)
        (blk_end && flags.eob) |=> $stable(flags.toggle)); // R5

    AST_NOSWAP_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (blk_end && !ctrl.swap_en) |=> !flags.mask); // R6

    AST_OVR_FROM_REJECT: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.ovr) |-> $past(dma_req && ctrl.chan_en && !flags.mask)); // R7

    AST_MASK_HELD_BY_PEND: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.mask) |-> !$past(flags.pend)); // R9

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags.eob || flags.ovr)); // R10

endmodule

bind dma_blockend_ctrl dbe_ctrl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .dma_req (dma_req),
    .dma_ack (dma_ack),
    .irq     (irq),
    .blk_end (evt.blk_end),
    .ctrl    (ctrl_q),
    .flags   (flags_q)
);

// File: tb/dma_blockend_ctrl_tb.sv
`timescale 1ns/1ps
module dma_blockend_ctrl_tb;

    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_waddr = '0;
    logic [PW-1:0] reg_wdata = '0;
    logic [2:0]    reg_raddr = '0;
    logic [PW-1:0] reg_rdata;
    logic          dma_req = 1'b0;
    logic          dma_ack;
    logic [PW-1:0] dma_addr;
    logic          irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dma_blockend_ctrl #(.PW(PW)) u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .dma_req(dma_req), .dma_ack(dma_ack), .dma_addr(dma_addr), .irq(irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    logic [15:0] m_ptr [4];
    logic [4:0]  m_ctrl;
    bit m_eob, m_tog, m_mask, m_pend, m_ovr, m_ack;
    logic [15:0] m_ackaddr;

    function automatic logic [15:0] m_read(input logic [2:0] a);
        case (a)
            3'd4:    return {11'd0, m_ctrl};
            3'd5:    return {14'd0, m_tog, m_eob};
            3'd6:    return {14'd0, m_ovr, m_pend};
            3'd7:    return {15'd0, m_mask};
            default: return m_ptr[a[1:0]];
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_ptr[i]) m_ptr[i] = '0;
            m_ctrl = '0; m_eob = 0; m_tog = 0; m_mask = 0; m_pend = 0; m_ovr = 0;
            m_ack = 0; m_ackaddr = '0;
        end else begin
            bit en, srv, rej, fin;
            int ia, ic;
            logic [15:0] na, nc;
            bit n_eob, n_tog, n_mask, n_pend, n_ovr;
            en  = m_ctrl[0];
            srv = dma_req && en && m_mask;
            rej = dma_req && en && !m_mask;
            ia = m_tog ? 2 : 0;
            ic = ia + 1;
            na = m_ptr[ia] + 16'd1;
            nc = m_ptr[ic] - 16'd1;
            fin = srv && (nc == 16'd0);
            n_eob = m_eob; n_tog = m_tog; n_mask = m_mask; n_pend = m_pend; n_ovr = m_ovr;
            if (reg_we) begin
                case (reg_waddr)
                    3'd5: if (!reg_wdata[0]) n_eob = 0; else if (m_ctrl[2]) n_eob = 1;
                    3'd6: begin if (reg_wdata[0]) n_pend = 0; if (reg_wdata[1]) n_ovr = 0; end
                    3'd7: if (!reg_wdata[0]) n_mask = 0; else if (!m_pend) n_mask = 1;
                    default: ;
                endcase
            end
            if (rej) begin n_pend = 1; n_ovr = 1; end
            if (fin) begin
                n_eob = 1;
                if (m_eob || !m_ctrl[1]) n_mask = 0;
                else n_tog = !m_tog;
            end
            if (srv) m_ackaddr = m_ptr[ia];
            m_ack = srv;
            if (reg_we && reg_waddr < 3'd4) m_ptr[reg_waddr[1:0]] = reg_wdata;
            if (reg_we && reg_waddr == 3'd4) m_ctrl = reg_wdata[4:0];
            if (srv) begin m_ptr[ia] = na; m_ptr[ic] = nc; end
            m_eob = n_eob; m_tog = n_tog; m_mask = n_mask; m_pend = n_pend; m_ovr = n_ovr;
        end
    end

    // compare every cycle, 1 ns before the rising edge
    always @(negedge clk) begin
        #3;
        if (!rst && !done) begin
            chk(dma_ack, m_ack, "R2 ack vs model");
            if (m_ack) chk(dma_addr, m_ackaddr, "R2 addr vs model");
            chk(irq, (m_eob && m_ctrl[3]) || (m_ovr && m_ctrl[4]), "R10 irq vs model");
            chk(reg_rdata, m_read(reg_raddr), "R4 readback vs model");
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); reg_we = 1; reg_waddr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic req1();
        @(negedge clk); dma_req = 1;
        @(negedge clk); dma_req = 0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
        reg_raddr = a; #1;
        chk(reg_rdata, exp, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        // R1 reset state
        for (int a = 0; a < 8; a++) rd(3'(a), 16'h0, "R1 reset register");
        chk(dma_ack, 0, "R1 ack after reset");
        chk(irq, 0, "R1 irq after reset");

        wr(0, 16'h1000); wr(1, 16'd3); wr(2, 16'h2000); wr(3, 16'd2);
        wr(4, 16'h001B);
        wr(7, 16'h1);
        rd(7, 16'h1, "R9 mask set with pending clear");

        req1(); chk(dma_ack, 1, "R2 first ack"); chk(dma_addr, 16'h1000, "R2 first addr");
        rd(1, 16'd2, "R2 count decremented");
        req1(); chk(dma_addr, 16'h1001, "R2 second addr");
        req1(); chk(dma_addr, 16'h1002, "R3 last addr");
        rd(5, 16'h3, "R3 R4 eob set and toggle flipped");
        chk(irq, 1, "R10 irq on eob");
        req1(); chk(dma_addr, 16'h2000, "R4 odd pair in use");
        repeat (3) @(negedge clk);
        chk(irq, 1, "R10 irq held");
        wr(0, 16'h1100); wr(1, 16'd2);
        wr(5, 16'h0);
        rd(5, 16'h2, "R8 eob cleared by writing 0");
        chk(irq, 0, "R10 irq drops");
        req1(); chk(dma_addr, 16'h2001, "R4 odd last");
        rd(5, 16'h1, "R4 toggle back to even");

        // second end with EOB still up
        req1(); req1(); chk(dma_addr, 16'h1101, "R5 even last");
        rd(5, 16'h1, "R5 toggle kept, eob kept");
        rd(7, 16'h0, "R5 mask cleared");

        req1(); chk(dma_ack, 0, "R7 no ack when masked");
        rd(6, 16'h3, "R7 pending and overrun");
        wr(7, 16'h1); rd(7, 16'h0, "R9 mask set ignored while pending");
        wr(6, 16'h1); rd(6, 16'h2, "R7 pending cleared alone");
        wr(7, 16'h1); rd(7, 16'h1, "R9 mask set after pending cleared");
        wr(6, 16'h2); rd(6, 16'h0, "R7 overrun cleared");

        wr(5, 16'h0); wr(5, 16'h1); rd(5, 16'h0, "R8 set refused without test enable");
        wr(4, 16'h001F); wr(5, 16'h1); rd(5, 16'h1, "R8 set with test enable");
        chk(irq, 1, "R8 irq from test write");
        wr(5, 16'h0);

        // no swap mode
        wr(4, 16'h0019); wr(1, 16'd1);
        req1(); rd(5, 16'h1, "R6 eob set, toggle unchanged");
        rd(7, 16'h0, "R6 mask cleared");
        wr(7, 16'h0); wr(7, 16'h1); rd(7, 16'h1, "R9 mask cleared then set");

        // channel disabled
        wr(4, 16'h0018); wr(5, 16'h0); wr(0, 16'h3000); wr(1, 16'd5);
        req1(); chk(dma_ack, 0, "R11 no ack when disabled");
        rd(0, 16'h3000, "R11 address untouched");
        rd(6, 16'h0, "R11 no pending");

        // overrun interrupt gating
        wr(4, 16'h0009); wr(7, 16'h0); req1();
        chk(irq, 0, "R10 overrun gated off");
        wr(4, 16'h0011); chk(irq, 1, "R10 overrun enabled");

        // random phase against the model
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            dma_req   = ($urandom_range(0, 2) != 0);
            reg_we    = ($urandom_range(0, 5) == 0);
            reg_waddr = 3'($urandom_range(0, 7));
            reg_wdata = (reg_waddr == 3'd4) ? 16'($urandom_range(0, 31) | 1)
                      : (reg_waddr[2] ? 16'($urandom_range(0, 3)) : 16'($urandom_range(1, 4)));
            reg_raddr = 3'($urandom_range(0, 7));
        end
        @(negedge clk); dma_req = 0; reg_we = 0;
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule